// File: doc/BRIEF.md
# PWM Differential Output Conditioner

This block sits between a multi-channel PWM modulator and the output drivers. Each channel delivers a one-bit pulse stream. The block turns each stream into a P/N differential pair and applies two corrections, both measured in master-clock cycles:

- **Pulse filtering.** High or low runs that are shorter than a programmable minimum width are removed.
- **Skew.** The N leg is delayed relative to the P leg by a programmable number of cycles.

Every channel shares one minimum-width setting and one skew setting.

A two-register configuration port holds the settings:

- **Address 0** holds the 5-bit minimum width.
- **Address 1** packs the 3-bit skew in bits [7:5] and a 5-bit per-channel delay field in bits [4:0]. The per-channel delay field is stored for readback only.

Settings can only be changed while the power-down input is high. During power-down every output is held low and all pulse-filter and skew state is cleared, so the channels restart cleanly when power-down is released.

Top module: `pwm_out_conditioner`

## Requirements
- R1: After reset, both configuration registers read 0. With power-down low and all inputs low, every P output is 0 and every N output is 1.
- R2: A write while power-down is 1 is stored. The value then reads back from the same address (cfg_addr 0 or 1) as combinational data on cfg_rdata. At address 0, bits [7:5] read as 0. At address 1, cfg_wdata[7:5] is the skew and cfg_wdata[4:0] is the channel-delay field.
- R3: A write while power-down is 0 leaves both registers unchanged.
- R4: While power-down is 1, every P and N output is 0 in the same cycle. The filters also restart from a low level.
- R5: With minimum width 0, the P output copies its input one clock later, and every pulse passes, including pulses of a single cycle.
- R6: With minimum width M ≥ 1, a high or low input run shorter than M cycles leaves P unchanged.
- R7: With minimum width M ≥ 1, a run of at least M cycles appears on P delayed by exactly M clocks, with its width preserved.
- R8: N equals the complement of P delayed by D clocks, where D is the skew value (0 to 7). With D = 0 the legs are exact complements.
- R9: The channel-delay field has no effect on the P or N timing.
- R10: Channels are filtered independently, all under the shared settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn | input | 1 | Power-down: enables writes, silences outputs |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Register select: 0 = minimum width, 1 = skew/channel delay |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Readback of the selected register |
| pwm_in | input | NUM_CH | Raw PWM stream, one bit per channel |
| pwm_p | output | NUM_CH | Positive output leg per channel |
| pwm_n | output | NUM_CH | Negative output leg per channel |

## Verification
The bench uses the default parameters: four channels, a 5-bit minimum-width field and a 3-bit skew field. Both extreme skew values (0 and 7) can therefore be reached, as can a minimum width large enough to separate suppressed runs from passed runs on each side of the threshold. With four channels, one run length per channel can be driven in a single pass. This exercises the shared setting against independent per-channel filtering at run lengths just below, at and above the minimum.

// File: rtl/pwmc_pkg.sv
`timescale 1ns/1ps
package pwmc_pkg;
  localparam int REG_W = 8;

  typedef enum logic {
    SEL_MINW = 1'b0,
    SEL_SKEW = 1'b1
  } cfg_sel_e;

  // A zero minimum behaves as a one-cycle minimum (plain register stage).
  function automatic logic [15:0] eff_limit(input logic [15:0] m);
    return (m == 16'd0) ? 16'd1 : m;
  endfunction

  // True when the run seen so far, counting this cycle, meets the limit.
  function automatic logic run_done(input logic [15:0] cnt, input logic [15:0] lim);
    return (cnt + 16'd1) >= lim;
  endfunction
endpackage

// File: rtl/pwmc_cfg_regs.sv
`timescale 1ns/1ps
module pwmc_cfg_regs #(
  parameter int MINW_W = 5,
  parameter int SKEW_W = 3,
  parameter int CHD_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn,
  input  logic              wr,
  input  logic              addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [MINW_W-1:0] minw_q,
  output logic [SKEW_W-1:0] skew_q
);
  import pwmc_pkg::*;
  localparam int PAD_W = pwmc_pkg::REG_W - MINW_W;

  logic [CHD_W-1:0] chd_q;
  logic             wr_minw, wr_skew;

  assign wr_minw = wr && pdn && (cfg_sel_e'(addr) == SEL_MINW);
  assign wr_skew = wr && pdn && (cfg_sel_e'(addr) == SEL_SKEW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      minw_q <= '0;
      skew_q <= '0;
      chd_q  <= '0;
    end else begin
      if (wr_minw) minw_q <= wdata[MINW_W-1:0];
      if (wr_skew) begin
        skew_q <= wdata[CHD_W +: SKEW_W];
        chd_q  <= wdata[CHD_W-1:0];
      end
    end
  end

  always_comb begin
    if (cfg_sel_e'(addr) == SEL_MINW) rdata = {{PAD_W{1'b0}}, minw_q};
    else                              rdata = {skew_q, chd_q};
  end

  assert_ignore_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !pdn) |=> ($stable(minw_q) && $stable(skew_q) && $stable(chd_q)));

  assert_take_minw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && pdn && !addr) |=> (minw_q == $past(wdata[MINW_W-1:0])));
endmodule

// File: rtl/pwmc_min_filter.sv
`timescale 1ns/1ps
module pwmc_min_filter #(
  parameter int MINW_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn,
  input  logic [MINW_W-1:0] minw,
  input  logic              din,
  output logic              dout
);
  import pwmc_pkg::*;

  logic [MINW_W-1:0] cnt_q;
  logic [15:0]       limit;
  logic              differs;
  logic              flip;

  assign limit   = eff_limit({{(16-MINW_W){1'b0}}, minw});
  assign differs = (din != dout);
  assign flip    = differs && run_done({{(16-MINW_W){1'b0}}, cnt_q}, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dout  <= 1'b0;
    end else if (pdn) begin
      cnt_q <= '0;
      dout  <= 1'b0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (flip) begin
      cnt_q <= '0;
      dout  <= din;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn |-> ({{(16-MINW_W){1'b0}}, cnt_q} < limit));

  assert_flip_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pdn && flip) |=> (dout == $past(din)));

  assert_pdn_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |=> (cnt_q == '0 && !dout));
endmodule

// File: rtl/pwmc_skew.sv
`timescale 1ns/1ps
module pwmc_skew #(
  parameter int SKEW_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn,
  input  logic [SKEW_W-1:0] skew,
  input  logic              cond,
  output logic              p,
  output logic              n
);
  localparam int DEPTH = (1 << SKEW_W) - 1;

  logic [DEPTH-1:0] sr_q;
  logic             tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sr_q <= '0;
    else if (pdn) sr_q <= '0;
    else          sr_q <= {sr_q[DEPTH-2:0], cond};
  end

  always_comb begin
    tap = cond;
    for (int i = 0; i < DEPTH; i++) begin
      if (skew == SKEW_W'(i + 1)) tap = sr_q[i];
    end
  end

  assign p = !pdn && cond;
  assign n = !pdn && !tap;

  assert_skew_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pdn && $past(!pdn) && skew == SKEW_W'(1)) |-> (n == !$past(cond)));
endmodule

// File: rtl/pwm_out_conditioner.sv
`timescale 1ns/1ps
module pwm_out_conditioner #(
  parameter int NUM_CH = 4,
  parameter int MINW_W = 5,
  parameter int SKEW_W = 3,
  parameter int CHD_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn,
  input  logic              cfg_wr,
  input  logic              cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [NUM_CH-1:0] pwm_in,
  output logic [NUM_CH-1:0] pwm_p,
  output logic [NUM_CH-1:0] pwm_n
);
  logic [MINW_W-1:0] minw;
  logic [SKEW_W-1:0] skew;
  logic [NUM_CH-1:0] cond;

  pwmc_cfg_regs #(.MINW_W(MINW_W), .SKEW_W(SKEW_W), .CHD_W(CHD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .minw_q(minw), .skew_q(skew)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwmc_min_filter #(.MINW_W(MINW_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .pdn(pdn), .minw(minw),
      .din(pwm_in[c]), .dout(cond[c])
    );
    pwmc_skew #(.SKEW_W(SKEW_W)) u_skew (
      .clk(clk), .rst_n(rst_n), .pdn(pdn), .skew(skew),
      .cond(cond[c]), .p(pwm_p[c]), .n(pwm_n[c])
    );
  end

  assert_pdn_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |-> (pwm_p == '0 && pwm_n == '0));

  assert_no_skew_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pdn && skew == '0) |-> (pwm_n == ~pwm_p));
endmodule

// File: tb/pwm_out_conditioner_test.sv
`timescale 1ns/1ps
module pwm_out_conditioner_test;
  localparam int NUM_CH = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pdn = 1'b0;
  logic              cfg_wr = 1'b0;
  logic              cfg_addr = 1'b0;
  logic [7:0]        cfg_wdata = '0;
  logic [7:0]        cfg_rdata;
  logic [NUM_CH-1:0] pwm_in = '0;
  logic [NUM_CH-1:0] pwm_p, pwm_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwm_out_conditioner #(.NUM_CH(NUM_CH)) uut (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pwm_in(pwm_in),
    .pwm_p(pwm_p), .pwm_n(pwm_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(1);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  // Program both settings under power-down, then release with inputs low.
  task automatic setup(input logic [4:0] m, input logic [7:0] skew_reg);
    pwm_in = '0;
    pdn = 1'b1;
    tick(1);
    wr(1'b0, {3'b000, m});
    wr(1'b1, skew_reg);
    pdn = 1'b0;
    tick(10);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(1'b0, d); check("R1 minw reset", d, 0);
    rd(1'b1, d); check("R1 skew reset", d, 0);
    check("R1 P idle", pwm_p, 4'b0000);
    check("R1 N idle", pwm_n, 4'b1111);
  endtask

  task automatic t_cfg;
    logic [7:0] d;
    pdn = 1'b1;
    tick(1);
    #1 check("R4 P low in pdn", pwm_p, 0);
    check("R4 N low in pdn", pwm_n, 0);
    wr(1'b0, 8'h13); rd(1'b0, d); check("R2 minw write", d, 8'h13);
    wr(1'b0, 8'hFF); rd(1'b0, d); check("R2 minw upper bits zero", d, 8'h1F);
    wr(1'b1, 8'hA5); rd(1'b1, d); check("R2 skew/chd write", d, 8'hA5);
    pdn = 1'b0;
    tick(1);
    wr(1'b0, 8'h05); rd(1'b0, d); check("R3 minw unchanged", d, 8'h1F);
    wr(1'b1, 8'h00); rd(1'b1, d); check("R3 skew unchanged", d, 8'hA5);
  endtask

  task automatic t_pass;
    setup(5'd0, 8'h00);
    pwm_in[0] = 1'b1;
    tick(1);
    check("R5 single pulse P", pwm_p[0], 1);
    check("R8 D=0 N complement", pwm_n[0], 0);
    pwm_in[0] = 1'b0;
    tick(1);
    check("R5 single pulse ends", pwm_p[0], 0);
    check("R8 D=0 N back", pwm_n[0], 1);
  endtask

  task automatic t_minw;
    setup(5'd5, 8'h00);
    pwm_in[0] = 1'b1;
    tick(4);
    pwm_in[0] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      check("R6 short high suppressed", pwm_p[0], 0);
    end
    pwm_in[0] = 1'b1;
    tick(4); check("R7 not yet risen", pwm_p[0], 0);
    tick(1); check("R7 rises after M", pwm_p[0], 1);
    tick(2);
    pwm_in[0] = 1'b0;
    tick(4); check("R7 still high", pwm_p[0], 1);
    tick(1); check("R7 falls after M", pwm_p[0], 0);
    pwm_in[0] = 1'b1;
    tick(10);
    check("R7 steady high", pwm_p[0], 1);
    pwm_in[0] = 1'b0;
    tick(3);
    pwm_in[0] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      check("R6 short low suppressed", pwm_p[0], 1);
    end
  endtask

  task automatic t_skew(input logic [2:0] dly, input logic [4:0] chd, input string req);
    setup(5'd0, {dly, chd});
    pwm_in[1] = 1'b1;
    tick(1);
    check(req, pwm_p[1], 1);
    if (dly > 1) begin
      tick(int'(dly) - 1);
      check(req, pwm_n[1], 1);
      tick(1);
    end else begin
      tick(int'(dly));
    end
    check(req, pwm_n[1], 0);
  endtask

  task automatic t_multi;
    setup(5'd2, 8'h00);
    pwm_in = 4'b0111;
    tick(1); pwm_in = 4'b0110;
    tick(1); pwm_in = 4'b0100;
    check("R10 after 2 cycles", pwm_p, 4'b0110);
    tick(1); pwm_in = 4'b0000;
    check("R10 after 3 cycles", pwm_p, 4'b0110);
    tick(1); check("R10 ch1 ends", pwm_p, 4'b0100);
    tick(1); check("R10 ch2 ends", pwm_p, 4'b0000);
  endtask

  task automatic t_pdn_mid;
    setup(5'd0, 8'h00);
    pwm_in = 4'b1111;
    tick(3);
    check("R5 all high", pwm_p, 4'b1111);
    pdn = 1'b1;
    #1 check("R4 P low at once", pwm_p, 0);
    check("R4 N low at once", pwm_n, 0);
    tick(2);
    pwm_in = '0;
    pdn = 1'b0;
    #1 check("R4 restart low P", pwm_p, 0);
    check("R4 restart N", pwm_n, 4'b1111);
  endtask

  initial begin
    #1_600_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_cfg();
    t_pass();
    t_minw();
    t_skew(3'd3, 5'd0,  "R8 skew 3");
    t_skew(3'd7, 5'd0,  "R8 skew 7");
    t_skew(3'd3, 5'd31, "R9 chd ignored");
    t_skew(3'd1, 5'd31, "R8 skew 1");
    t_multi();
    t_pdn_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule